// File: doc/BRIEF.md
# Debug exception cause arbiter

This block sits beside the issue stage of a small processor pipeline and decides, for each issued instruction, whether a debug exception must be taken instead of completing it. Five debug sources are presented per instruction: an instruction-count expiry, an instruction-address breakpoint, a data breakpoint hit with the index of the comparator that matched, and the wide and narrow forms of the breakpoint instruction. The instruction-address comparator is part of the block, with its address register and enable bit written through two simple write ports.

Every source is gated by the current interrupt level: debug exceptions are only taken while that level is strictly below the debug level (6 by default). At or above the debug level all sources are dropped silently and the instruction proceeds. When an exception is taken, a single winning source is chosen by fixed priority, and in one clock edge the block loads a bit-coded cause word, captures the instruction's PC as the exception PC, and produces the new low status bits (exception flag plus the debug level as the new interrupt level). A one-cycle `take_debug` pulse tells the pipeline to squash the instruction and redirect.

Top module: `dbg_cause_arbiter`

## Requirements
- R1: A synchronous active-high reset clears take_debug, cause, epc, new_ps_low, the instruction-breakpoint enable bit and the instruction-breakpoint address to zero.
- R2: A debug exception is taken only when cur_level is strictly less than DBG_LEVEL; at or above it, take_debug stays 0 and cause, epc and new_ps_low keep their previous values.
- R3: The cause word uses one bit per source: bit 0 (0x1) instruction-count expiry, bit 1 (0x2) instruction-address breakpoint, bit 2 (0x4) data breakpoint, bit 3 (0x8) wide breakpoint instruction, bit 4 (0x10) narrow breakpoint instruction; exactly one of bits 4:0 is set after an exception.
- R4: For a data breakpoint, the matching comparator index dbrk_idx is placed in the cause word starting at bit 8 (cause[8 +: IDX_W]); for any other winner those bits are zero.
- R5: On a taken exception new_ps_low becomes {1'b1, DBG_LEVEL}: bit 4 is the exception flag, bits 3:0 the new interrupt level (0x16 by default).
- R6: On a taken exception epc holds the pc of the issued instruction that caused it.
- R7: The instruction-address breakpoint fires when pc equals the stored breakpoint address and the enable bit (bit 0 of the enable write data) is set; with the enable cleared it never fires.
- R8: When several sources fire for one instruction, the winner follows the fixed priority instruction count > instruction-address breakpoint > data breakpoint > wide breakpoint > narrow breakpoint, so an address breakpoint at the same PC as a breakpoint instruction reports 0x2.
- R9: Without issue_valid no source is considered and nothing is taken.
- R10: An instruction issued at a clock edge produces take_debug, cause, epc and new_ps_low at that same edge (visible the cycle after issue); take_debug is a one-cycle pulse, and writes to the breakpoint address or enable apply only to instructions issued at later edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction is issued this cycle |
| pc | input | XLEN | Address of the issued instruction |
| cur_level | input | LVL_W | Current interrupt level |
| icount_exp | input | 1 | Instruction-count expiry for this instruction |
| dbrk_hit | input | 1 | Data breakpoint matched for this instruction |
| dbrk_idx | input | IDX_W | Index of the matching data comparator |
| brk_wide | input | 1 | Instruction is the wide breakpoint instruction |
| brk_narrow | input | 1 | Instruction is the narrow breakpoint instruction |
| ibrk_addr_we | input | 1 | Write strobe for the breakpoint address |
| ibrk_addr_wdata | input | XLEN | Breakpoint address write data |
| ibrk_en_we | input | 1 | Write strobe for the breakpoint enable |
| ibrk_en_wdata | input | 1 | Enable write data (bit 0 of the enable register) |
| take_debug | output | 1 | One-cycle pulse: debug exception taken |
| cause | output | XLEN | Cause word of the last taken exception |
| epc | output | XLEN | Exception PC of the last taken exception |
| new_ps_low | output | LVL_W+1 | Low status bits after the last taken exception |

## Verification
The bench builds the block with NUM_DCOMP set to 4, so the comparator index is two bits wide and indices up to 3 land in cause bits 9:8, while DBG_LEVEL stays at 6 so levels 5, 6 and 7 around the gate boundary are all reachable from random and directed stimulus. Random PCs are drawn from a small pool that includes the programmed breakpoint address, so address matches, simultaneous sources and enable toggling occur often enough to exercise every priority pair.

// File: rtl/dbg_arb_pkg.sv
`timescale 1ns/1ps
package dbg_arb_pkg;

  localparam int SRC_N = 5;

  // Source index doubles as the cause bit position.
  typedef enum logic [2:0] {
    SRC_ICOUNT     = 3'd0,
    SRC_IBRK       = 3'd1,
    SRC_DBRK       = 3'd2,
    SRC_BRK_WIDE   = 3'd3,
    SRC_BRK_NARROW = 3'd4
  } dbg_src_e;

  // Keep only the lowest set bit: lowest index has highest priority.
  function automatic logic [SRC_N-1:0] lowest_set(input logic [SRC_N-1:0] v);
    return v & (~v + SRC_N'(1));
  endfunction

  function automatic logic [SRC_N-1:0] src_code(input dbg_src_e s);
    return SRC_N'(1) << s;
  endfunction

endpackage

// File: rtl/dbg_ibrk_cmp.sv
`timescale 1ns/1ps
module dbg_ibrk_cmp #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            addr_we,
  input  logic [XLEN-1:0] addr_wdata,
  input  logic            en_we,
  input  logic            en_wdata,
  input  logic [XLEN-1:0] pc,
  output logic            hit
);

  logic [XLEN-1:0] addr_q;
  logic            en_q;
  logic            addr_eq;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (addr_we) addr_q <= addr_wdata;
      if (en_we)   en_q   <= en_wdata;
    end
  end

  assign addr_eq = (pc == addr_q);
  assign hit     = en_q & addr_eq;

  AST_EN_WRITE: assert property (@(posedge clk) disable iff (rst)
    en_we |=> (en_q == $past(en_wdata))); // R7
  AST_ADDR_WRITE: assert property (@(posedge clk) disable iff (rst)
    addr_we |=> (addr_q == $past(addr_wdata))); // R10

endmodule

// File: rtl/dbg_cause_pick.sv
`timescale 1ns/1ps
module dbg_cause_pick
  import dbg_arb_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int IDX_W   = 1,
  parameter int IDX_LSB = 8
) (
  input  logic [SRC_N-1:0] req,
  input  logic [IDX_W-1:0] dbrk_idx,
  output logic             any,
  output logic [SRC_N-1:0] grant,
  output logic [XLEN-1:0]  word
);

  function automatic logic [XLEN-1:0] build_cause(input logic [SRC_N-1:0] g,
                                                  input logic [IDX_W-1:0] idx);
    logic [XLEN-1:0] w;
    w = '0;
    w[SRC_N-1:0] = g;
    if ((g & src_code(SRC_DBRK)) != '0) w[IDX_LSB +: IDX_W] = idx;
    return w;
  endfunction

  assign any   = |req;
  assign grant = lowest_set(req);
  assign word  = build_cause(grant, dbrk_idx);

endmodule

// File: rtl/dbg_entry_regs.sv
`timescale 1ns/1ps
module dbg_entry_regs #(
  parameter int XLEN  = 32,
  parameter int PS_W  = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take_in,
  input  logic [XLEN-1:0] pc_in,
  input  logic [XLEN-1:0] cause_in,
  input  logic [PS_W-1:0] ps_in,
  output logic            take_q,
  output logic [XLEN-1:0] cause_q,
  output logic [XLEN-1:0] epc_q,
  output logic [PS_W-1:0] ps_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      take_q  <= 1'b0;
      cause_q <= '0;
      epc_q   <= '0;
      ps_q    <= '0;
    end else begin
      take_q <= take_in;
      if (take_in) begin
        cause_q <= cause_in;
        epc_q   <= pc_in;
        ps_q    <= ps_in;
      end
    end
  end

  AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    take_q |-> $onehot(cause_q[4:0])); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!take_q && !$past(rst)) |-> ($stable(cause_q) && $stable(epc_q) && $stable(ps_q))); // R2
  AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    take_in |=> (epc_q == $past(pc_in))); // R6

endmodule

// File: rtl/dbg_cause_arbiter.sv
`timescale 1ns/1ps
module dbg_cause_arbiter
  import dbg_arb_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int LVL_W     = 4,
  parameter int DBG_LEVEL = 6,
  parameter int NUM_DCOMP = 2,
  parameter int IDX_LSB   = 8,
  localparam int IDX_W    = (NUM_DCOMP > 1) ? $clog2(NUM_DCOMP) : 1,
  localparam int PS_W     = LVL_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_valid,
  input  logic [XLEN-1:0]  pc,
  input  logic [LVL_W-1:0] cur_level,
  input  logic             icount_exp,
  input  logic             dbrk_hit,
  input  logic [IDX_W-1:0] dbrk_idx,
  input  logic             brk_wide,
  input  logic             brk_narrow,
  input  logic             ibrk_addr_we,
  input  logic [XLEN-1:0]  ibrk_addr_wdata,
  input  logic             ibrk_en_we,
  input  logic             ibrk_en_wdata,
  output logic             take_debug,
  output logic [XLEN-1:0]  cause,
  output logic [XLEN-1:0]  epc,
  output logic [PS_W-1:0]  new_ps_low
);

  localparam logic [LVL_W-1:0] DBG_LVL_V = LVL_W'(DBG_LEVEL);

  function automatic logic [PS_W-1:0] entry_ps();
    return {1'b1, DBG_LVL_V};
  endfunction

  logic             ibrk_hit;
  logic             level_ok;
  logic             qualify;
  logic [SRC_N-1:0] raw_req;
  logic [SRC_N-1:0] req;
  logic             any_req;
  logic [SRC_N-1:0] grant;
  logic [XLEN-1:0]  cause_word;

  dbg_ibrk_cmp #(.XLEN(XLEN)) u_ibrk (
    .clk        (clk),
    .rst        (rst),
    .addr_we    (ibrk_addr_we),
    .addr_wdata (ibrk_addr_wdata),
    .en_we      (ibrk_en_we),
    .en_wdata   (ibrk_en_wdata),
    .pc         (pc),
    .hit        (ibrk_hit)
  );

  assign level_ok = (cur_level < DBG_LVL_V);
  assign qualify  = issue_valid & level_ok;

  always_comb begin
    raw_req = '0;
    raw_req[SRC_ICOUNT]     = icount_exp;
    raw_req[SRC_IBRK]       = ibrk_hit;
    raw_req[SRC_DBRK]       = dbrk_hit;
    raw_req[SRC_BRK_WIDE]   = brk_wide;
    raw_req[SRC_BRK_NARROW] = brk_narrow;
  end

  assign req = qualify ? raw_req : '0;

  dbg_cause_pick #(.XLEN(XLEN), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) u_pick (
    .req      (req),
    .dbrk_idx (dbrk_idx),
    .any      (any_req),
    .grant    (grant),
    .word     (cause_word)
  );

  dbg_entry_regs #(.XLEN(XLEN), .PS_W(PS_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .take_in  (any_req),
    .pc_in    (pc),
    .cause_in (cause_word),
    .ps_in    (entry_ps()),
    .take_q   (take_debug),
    .cause_q  (cause),
    .epc_q    (epc),
    .ps_q     (new_ps_low)
  );

  AST_LEVEL_GATE: assert property (@(posedge clk) disable iff (rst)
    (cur_level >= DBG_LVL_V) |=> !take_debug); // R2
  AST_NO_ISSUE: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |=> !take_debug); // R9
  AST_PS_ENTRY: assert property (@(posedge clk) disable iff (rst)
    take_debug |-> (new_ps_low == {1'b1, DBG_LVL_V})); // R5
  AST_ICOUNT_WINS: assert property (@(posedge clk) disable iff (rst)
    (qualify && icount_exp) |=> (take_debug && cause[4:0] == 5'h01)); // R8
  AST_DBRK_INDEX: assert property (@(posedge clk) disable iff (rst)
    (take_debug && cause[2]) |-> (cause[IDX_LSB +: IDX_W] == $past(dbrk_idx))); // R4

endmodule

// File: tb/tb_dbg_cause_arbiter.sv
`timescale 1ns/1ps
module tb_dbg_cause_arbiter;

  localparam int XLEN = 32;
  localparam int IW   = 2;

  logic clk = 1'b0;
  logic rst;
  logic issue_valid;
  logic [XLEN-1:0] pc;
  logic [3:0] cur_level;
  logic icount_exp, dbrk_hit, brk_wide, brk_narrow;
  logic [IW-1:0] dbrk_idx;
  logic ibrk_addr_we, ibrk_en_we, ibrk_en_wdata;
  logic [XLEN-1:0] ibrk_addr_wdata;
  logic take_debug;
  logic [XLEN-1:0] cause, epc;
  logic [4:0] new_ps_low;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dbg_cause_arbiter #(.NUM_DCOMP(4)) dut (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .pc(pc), .cur_level(cur_level),
    .icount_exp(icount_exp), .dbrk_hit(dbrk_hit), .dbrk_idx(dbrk_idx),
    .brk_wide(brk_wide), .brk_narrow(brk_narrow),
    .ibrk_addr_we(ibrk_addr_we), .ibrk_addr_wdata(ibrk_addr_wdata),
    .ibrk_en_we(ibrk_en_we), .ibrk_en_wdata(ibrk_en_wdata),
    .take_debug(take_debug), .cause(cause), .epc(epc), .new_ps_low(new_ps_low)
  );

  // bench model state
  logic [XLEN-1:0] m_addr, m_cause, m_epc;
  logic m_en, m_take;
  logic [4:0] m_ps;

  function automatic logic [XLEN-1:0] exp_cause(input logic ic, ib, dh, wd, nr,
                                                input logic [IW-1:0] di);
    if (ic) return 32'h1;
    if (ib) return 32'h2;
    if (dh) return 32'h4 | (32'(di) << 8);
    if (wd) return 32'h8;
    return 32'h10;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic iv, input logic [XLEN-1:0] p, input logic [3:0] lvl,
                     input logic ic, input logic wd, input logic nr, input logic dh,
                     input logic [IW-1:0] di, input logic awe, input logic [XLEN-1:0] awd,
                     input logic ewe, input logic ewd, input string tag);
    logic ib;
    @(negedge clk);
    issue_valid = iv; pc = p; cur_level = lvl; icount_exp = ic; brk_wide = wd;
    brk_narrow = nr; dbrk_hit = dh; dbrk_idx = di; ibrk_addr_we = awe;
    ibrk_addr_wdata = awd; ibrk_en_we = ewe; ibrk_en_wdata = ewd;
    ib = m_en && (p == m_addr);
    m_take = iv && (lvl < 4'd6) && (ic || ib || dh || wd || nr);
    if (m_take) begin
      m_cause = exp_cause(ic, ib, dh, wd, nr, di);
      m_epc   = p;
      m_ps    = 5'h16;
    end
    if (awe) m_addr = awd;
    if (ewe) m_en = ewd;
    @(posedge clk); #1;
    chk(tag, "take_debug", 32'(take_debug), 32'(m_take));
    chk(tag, "cause", cause, m_cause);
    chk(tag, "epc", epc, m_epc);
    chk(tag, "new_ps_low", 32'(new_ps_low), 32'(m_ps));
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 idle");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; issue_valid = 0; pc = 0; cur_level = 0; icount_exp = 0; dbrk_hit = 0;
    dbrk_idx = 0; brk_wide = 0; brk_narrow = 0; ibrk_addr_we = 0; ibrk_addr_wdata = 0;
    ibrk_en_we = 0; ibrk_en_wdata = 0;
    m_addr = 0; m_cause = 0; m_epc = 0; m_en = 0; m_take = 0; m_ps = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "take_debug", 32'(take_debug), 0);
    chk("R1", "cause", cause, 0);
    chk("R1", "epc", epc, 0);
    chk("R1", "new_ps_low", 32'(new_ps_low), 0);
    @(negedge clk); rst = 1'b0;

    // R1/R7: enable cleared by reset, pc equals reset address 0 -> no hit
    cyc(1, 32'h0, 4'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 enable cleared");
    // R3/R5/R6/R10: wide and narrow break
    cyc(1, 32'hd000_0040, 4'd5, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R3 wide break");
    idle();
    cyc(1, 32'hd000_0044, 4'd0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R3 narrow break");
    // R2: level 6 and 7 ignored, state held
    cyc(1, 32'hd000_0048, 4'd6, 1, 1, 0, 1, 2'd1, 0, 0, 0, 0, "R2 level 6");
    cyc(1, 32'hd000_004c, 4'd7, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R2 level 7");
    // R10: address write and same-cycle match does not hit
    cyc(1, 32'h0000_0100, 4'd3, 0, 0, 0, 0, 0, 1, 32'h0000_0100, 1, 1, "R10 write latency");
    // R7/R8: address breakpoint beats breakpoint instruction at same pc
    cyc(1, 32'h0000_0100, 4'd3, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R8 ibrk over break");
    cyc(1, 32'h0000_0100, 4'd3, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7 ibrk alone");
    // R4: data breakpoint index 3 at bits 9:8
    cyc(1, 32'h0000_0200, 4'd2, 0, 0, 0, 1, 2'd3, 0, 0, 0, 0, "R4 dbrk idx3");
    cyc(1, 32'h0000_0204, 4'd2, 0, 1, 0, 1, 2'd2, 0, 0, 0, 0, "R8 dbrk over wide");
    // R8: all sources -> icount
    cyc(1, 32'h0000_0100, 4'd1, 1, 1, 1, 1, 2'd1, 0, 0, 0, 0, "R8 all sources");
    // R7: clear enable suppresses
    cyc(0, 32'h0, 4'd0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R7 clear enable");
    cyc(1, 32'h0000_0100, 4'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7 disabled");
    // R9: no issue
    cyc(0, 32'h0000_0300, 4'd0, 1, 1, 1, 1, 2'd2, 0, 0, 0, 0, "R9 no issue");
    // R10: take_debug is a single pulse on back-to-back events
    cyc(1, 32'h0000_0304, 4'd0, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R10 pulse a");
    cyc(1, 32'h0000_0308, 4'd0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R10 pulse b");
    idle();

    // random phase
    for (int i = 0; i < 600; i++) begin
      logic [XLEN-1:0] p;
      logic [3:0] lvl;
      int r;
      r = $urandom_range(0, 3);
      p = (r == 0) ? 32'h0000_0100 : (r == 1) ? 32'h0000_0180 : 32'(($urandom & 32'hff) << 2);
      r = $urandom_range(0, 9);
      lvl = (r < 6) ? 4'($urandom_range(0, 5)) : 4'($urandom_range(6, 15));
      cyc($urandom_range(0, 7) != 0, p, lvl,
          $urandom_range(0, 7) == 0, $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
          $urandom_range(0, 3) == 0, 2'($urandom),
          $urandom_range(0, 15) == 0, ($urandom_range(0, 1) == 0) ? 32'h0000_0100 : 32'h0000_0180,
          $urandom_range(0, 7) == 0, 1'($urandom),
          "R8 random mix");
    end

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule